// File: doc/BRIEF.md
# Serial Audio Port Register File

This block is the memory-mapped control and status face of a stereo serial audio port. Software configures the link through a small set of registers on a plain single-cycle bus. The registers are a global control word, a framing/format word, a read-only status word, an interrupt enable word, a write-one-to-clear acknowledge word and a bit-clock divider. One data address feeds the transmit FIFO on writes and drains the receive FIFO on reads.

Both 16-entry FIFOs live inside the block. The serial shifter outside the block takes transmit words with a pop strobe and delivers received words with a push strobe. The block turns FIFO fill levels and programmable 4-bit thresholds into service requests. It latches sticky overrun and underrun conditions and combines the enabled status conditions into one interrupt line.

A self-clearing reset bit in the control word empties both FIFOs and returns every register to its reset value. Software uses it before re-enabling the link after a mid-stream stop.

Top module: `audio_port_regs`

## Requirements
- R1: After reset every writable register reads 0, the status word reads 0x99 (transmit not full, both service requests, controller off), and `irq` is 0.
- R2: Control at 0x00 keeps link enable (bit 0), bit-clock direction (bit 2), transmit threshold (bits 11:8) and receive threshold (bits 15:12); bit 3 reads 0. Format at 0x04 keeps bits 0, 3, 4 and 5. Interrupt mask at 0x14 keeps bits 6:3. The divider at 0x60 keeps its low 7 bits. The configuration outputs follow these fields.
- R3: A write to 0x80 pushes the transmit FIFO. `tx_word` shows the oldest entry and `tx_pop` removes it, in write order. A write to a full (16-entry) FIFO is dropped, and status bit 0 reads 0 while the FIFO is full.
- R4: `rx_push` stores `rx_word`. A read of 0x80 returns the oldest received word and removes it. A read with the FIFO empty returns 0 and leaves it empty, and status bit 1 shows not-empty.
- R5: A push into a full receive FIFO drops the word and sets the overrun flag (status bit 6).
- R6: A `tx_pop` with the transmit FIFO empty sets the underrun flag (status bit 5) only while link enable is 1 and playback-disable (format bit 4) is 0.
- R7: Overrun and underrun stay set until a 1 is written to bit 6 or bit 5 of the clear register at 0x18. Zero bits and other bits have no effect, and a new event in the same cycle as its clear leaves the flag set.
- R8: Status bit 3 is 1 while the transmit count is at most the transmit threshold. Status bit 4 is 1 while the receive count is at least the receive threshold.
- R9: Status bit 2 (busy) is 1 when link enable and `frame_active` are both 1. Status bit 7 is 1 whenever link enable is 0.
- R10: `irq` is the OR over status bits 6:3, each gated by the same-numbered bit of the mask register.
- R11: Writing the control register with bit 3 set empties both FIFOs, clears both flags and returns all registers to reset values by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at 0x80) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tx_pop | input | 1 | Shifter takes the transmit head |
| tx_word | output | 32 | Transmit FIFO head |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | 32 | Received word |
| frame_active | input | 1 | Shifter is inside a frame |
| link_en | output | 1 | Link enable field |
| bclk_master | output | 1 | Bit-clock direction field |
| alt_format | output | 1 | MSB-justified framing select |
| loopback | output | 1 | Loopback field |
| play_en | output | 1 | Link enabled and playback not disabled |
| rec_en | output | 1 | Link enabled and recording not disabled |
| clk_div | output | 7 | Bit-clock divider |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. No FIFO count exceeds its depth, and an accepted push raises the count by one. The flags hold until acknowledged, a clear with no competing event drops a flag, and an event always sets it. A soft reset leaves registers and counts at zero, and the interrupt never rises with an all-zero mask. Only the bench scenarios can show the rest. That covers word ordering through both FIFOs and the dropped seventeenth word. It also covers the threshold boundaries, the gating of underrun by playback enable, and the exact status words read over the bus.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;

    localparam int TH_W = 4;

    // byte offsets on the register bus
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_FMT  = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_MASK = 8'h14;
    localparam logic [7:0] OFF_ICLR = 8'h18;
    localparam logic [7:0] OFF_DIV  = 8'h60;
    localparam logic [7:0] OFF_DATA = 8'h80;

    // control word fields
    localparam int C_LINK = 0;
    localparam int C_BCLK = 2;
    localparam int C_SRST = 3;
    localparam int C_TXTH = 8;
    localparam int C_RXTH = 12;

    // format word fields
    localparam int F_ALT     = 0;
    localparam int F_RECDIS  = 3;
    localparam int F_PLAYDIS = 4;
    localparam int F_LOOP    = 5;

    // status word fields
    localparam int S_TXNF = 0;
    localparam int S_RXNE = 1;
    localparam int S_BUSY = 2;
    localparam int S_TXSR = 3;
    localparam int S_RXSR = 4;
    localparam int S_UNR  = 5;
    localparam int S_OVR  = 6;
    localparam int S_OFF  = 7;

    typedef struct packed {
        logic [TH_W-1:0] rx_th;
        logic [TH_W-1:0] tx_th;
        logic            bclk_dir;
        logic            link_en;
    } ctrl_t;

    typedef struct packed {
        logic loopback;
        logic play_dis;
        logic rec_dis;
        logic alt;
    } fmt_t;

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.link_en  = w[C_LINK];
        c.bclk_dir = w[C_BCLK];
        c.tx_th    = w[C_TXTH +: TH_W];
        c.rx_th    = w[C_RXTH +: TH_W];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[C_LINK]          = c.link_en;
        w[C_BCLK]          = c.bclk_dir;
        w[C_TXTH +: TH_W]  = c.tx_th;
        w[C_RXTH +: TH_W]  = c.rx_th;
        return w;
    endfunction

    function automatic fmt_t word_to_fmt(input logic [31:0] w);
        fmt_t f;
        f.alt      = w[F_ALT];
        f.rec_dis  = w[F_RECDIS];
        f.play_dis = w[F_PLAYDIS];
        f.loopback = w[F_LOOP];
        return f;
    endfunction

    function automatic logic [31:0] fmt_to_word(input fmt_t f);
        logic [31:0] w;
        w = '0;
        w[F_ALT]     = f.alt;
        w[F_RECDIS]  = f.rec_dis;
        w[F_PLAYDIS] = f.play_dis;
        w[F_LOOP]    = f.loopback;
        return w;
    endfunction

    // mask bits [3:0] map onto status bits 6:3
    function automatic logic [3:0] word_to_mask(input logic [31:0] w);
        return w[S_OVR:S_TXSR];
    endfunction

endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R3
    push_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !(pop && !empty)) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/aud_flags.sv
module aud_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovr_evt,
    input  logic unr_evt,
    input  logic clr_ovr,
    input  logic clr_unr,
    output logic ovr,
    output logic unr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= 1'b0;
            unr <= 1'b0;
        end else begin
            if (ovr_evt)      ovr <= 1'b1;
            else if (clr_ovr) ovr <= 1'b0;
            if (unr_evt)      unr <= 1'b1;
            else if (clr_unr) unr <= 1'b0;
        end
    end

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !clr_ovr) |=> ovr);

    // R7
    unr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unr && !clr_unr) |=> unr);

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ovr && !ovr_evt) |=> !ovr);

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> ovr);

    // R6
    unr_set_chk: assert property (@(posedge clk) disable iff (rst)
        unr_evt |=> unr);

endmodule

// File: rtl/aud_status.sv
module aud_status
    import audio_regs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_en,
    input  logic             frame_active,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic [TH_W-1:0]  tx_th,
    input  logic [TH_W-1:0]  rx_th,
    input  logic             unr,
    input  logic             ovr,
    input  logic [3:0]       irq_mask,
    output logic [31:0]      status,
    output logic             irq
);

    logic tx_svc, rx_svc;
    logic [3:0] pending;

    assign tx_svc = int'(tx_cnt) <= int'(tx_th);
    assign rx_svc = int'(rx_cnt) >= int'(rx_th);

    always_comb begin
        status         = '0;
        status[S_TXNF] = !tx_full;
        status[S_RXNE] = !rx_empty;
        status[S_BUSY] = link_en && frame_active;
        status[S_TXSR] = tx_svc;
        status[S_RXSR] = rx_svc;
        status[S_UNR]  = unr;
        status[S_OVR]  = ovr;
        status[S_OFF]  = !link_en;
    end

    assign pending = status[S_OVR:S_TXSR] & irq_mask;
    assign irq     = |pending;

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_mask != 4'b0000));

endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
    import audio_regs_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 7,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_pop,
    output logic [DW-1:0]     tx_word,
    input  logic              rx_push,
    input  logic [DW-1:0]     rx_word,
    input  logic              frame_active,
    output logic              link_en,
    output logic              bclk_master,
    output logic              alt_format,
    output logic              loopback,
    output logic              play_en,
    output logic              rec_en,
    output logic [DIV_W-1:0]  clk_div,
    output logic              irq
);

    ctrl_t            ctrl_q;
    fmt_t             fmt_q;
    logic [3:0]       mask_q;
    logic [DIV_W-1:0] div_q;

    logic sel_ctrl, sel_fmt, sel_stat, sel_mask, sel_iclr, sel_div, sel_data;
    logic soft_rst, wipe;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0]    rx_head;
    logic ovr, unr, ovr_evt, unr_evt, clr_ovr, clr_unr;
    logic [31:0] status;

    assign sel_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
    assign sel_fmt  = bus_addr == ADDR_W'(OFF_FMT);
    assign sel_stat = bus_addr == ADDR_W'(OFF_STAT);
    assign sel_mask = bus_addr == ADDR_W'(OFF_MASK);
    assign sel_iclr = bus_addr == ADDR_W'(OFF_ICLR);
    assign sel_div  = bus_addr == ADDR_W'(OFF_DIV);
    assign sel_data = bus_addr == ADDR_W'(OFF_DATA);

    assign soft_rst = bus_wr && sel_ctrl && bus_wdata[C_SRST];
    assign wipe     = rst || soft_rst;

    always_ff @(posedge clk) begin
        if (wipe) begin
            ctrl_q <= '0;
            fmt_q  <= '0;
            mask_q <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) ctrl_q <= word_to_ctrl(bus_wdata);
            if (sel_fmt)  fmt_q  <= word_to_fmt(bus_wdata);
            if (sel_mask) mask_q <= word_to_mask(bus_wdata);
            if (sel_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    assign link_en     = ctrl_q.link_en;
    assign bclk_master = ctrl_q.bclk_dir;
    assign alt_format  = fmt_q.alt;
    assign loopback    = fmt_q.loopback;
    assign play_en     = ctrl_q.link_en && !fmt_q.play_dis;
    assign rec_en      = ctrl_q.link_en && !fmt_q.rec_dis;
    assign clk_div     = div_q;

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk  (clk),
        .rst  (wipe),
        .push (bus_wr && sel_data),
        .wdata(DW'(bus_wdata)),
        .pop  (tx_pop),
        .head (tx_word),
        .count(tx_cnt),
        .full (tx_full),
        .empty(tx_empty)
    );

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk  (clk),
        .rst  (wipe),
        .push (rx_push),
        .wdata(rx_word),
        .pop  (bus_rd && sel_data),
        .head (rx_head),
        .count(rx_cnt),
        .full (rx_full),
        .empty(rx_empty)
    );

    assign ovr_evt = rx_push && rx_full;
    assign unr_evt = tx_pop && tx_empty && play_en;
    assign clr_ovr = bus_wr && sel_iclr && bus_wdata[S_OVR];
    assign clr_unr = bus_wr && sel_iclr && bus_wdata[S_UNR];

    aud_flags u_flags (
        .clk    (clk),
        .rst    (wipe),
        .ovr_evt(ovr_evt),
        .unr_evt(unr_evt),
        .clr_ovr(clr_ovr),
        .clr_unr(clr_unr),
        .ovr    (ovr),
        .unr    (unr)
    );

    aud_status #(.CNT_W(CNT_W)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .link_en     (ctrl_q.link_en),
        .frame_active(frame_active),
        .tx_cnt      (tx_cnt),
        .rx_cnt      (rx_cnt),
        .tx_full     (tx_full),
        .rx_empty    (rx_empty),
        .tx_th       (ctrl_q.tx_th),
        .rx_th       (ctrl_q.rx_th),
        .unr         (unr),
        .ovr         (ovr),
        .irq_mask    (mask_q),
        .status      (status),
        .irq         (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = ctrl_to_word(ctrl_q);
        else if (sel_fmt)  bus_rdata = fmt_to_word(fmt_q);
        else if (sel_stat) bus_rdata = status;
        else if (sel_mask) bus_rdata[S_OVR:S_TXSR] = mask_q;
        else if (sel_div)  bus_rdata = 32'(div_q);
        else if (sel_data) bus_rdata = rx_empty ? '0 : 32'(rx_head);
    end

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_q == '0 && fmt_q == '0 && mask_q == '0 && div_q == '0
                      && tx_cnt == '0 && rx_cnt == '0 && !ovr && !unr));

endmodule

// File: tb/tb_audio_port_regs.sv
module tb_audio_port_regs;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0, rx_push = 1'b0, frame_active = 1'b0;
    logic [31:0] tx_word, rx_word = '0;
    logic        link_en, bclk_master, alt_format, loopback, play_en, rec_en, irq;
    logic [6:0]  clk_div;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] tx_q[$];
    logic [31:0] rx_q[$];

    always #(CLK_P/2) clk = ~clk;

    audio_port_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_word(tx_word),
        .rx_push(rx_push), .rx_word(rx_word), .frame_active(frame_active),
        .link_en(link_en), .bclk_master(bclk_master), .alt_format(alt_format),
        .loopback(loopback), .play_en(play_en), .rec_en(rec_en), .clk_div(clk_div), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] m,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v & m, exp);
    endtask

    // driver: pushes a transmit word and records what should come out
    task automatic send_tx(input logic [31:0] d);
        wr(8'h80, d);
        if (tx_q.size() < 16) tx_q.push_back(d);
    endtask

    // monitor: compares the head with the scoreboard, then pops it
    task automatic take_tx(input string req);
        @(negedge clk);
        chk(req, tx_word, tx_q.pop_front());
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic feed_rx(input logic [31:0] d);
        @(negedge clk); rx_push = 1'b1; rx_word = d;
        @(negedge clk); rx_push = 1'b0;
        if (rx_q.size() < 16) rx_q.push_back(d);
    endtask

    task automatic drain_rx(input string req);
        logic [31:0] v;
        rd(8'h80, v);
        chk(req, v, rx_q.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 status", 8'h0C, 32'hFFFF_FFFF, 32'h99);
        rd_chk("R1 ctrl", 8'h00, 32'hFFFF_FFFF, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 field masks and config outputs
        wr(8'h00, 32'hFFFF_FFF7);
        rd_chk("R2 ctrl", 8'h00, 32'hFFFF_FFFF, 32'h0000_FF05);
        chk("R2 link/bclk", {30'b0, link_en, bclk_master}, 32'h3);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 fmt", 8'h04, 32'hFFFF_FFFF, 32'h39);
        chk("R2 fmt outs", {28'b0, alt_format, loopback, play_en, rec_en}, 32'hC);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R2 mask", 8'h14, 32'hFFFF_FFFF, 32'h78);
        wr(8'h60, 32'hFFFF_FFFF);
        rd_chk("R2 div", 8'h60, 32'hFFFF_FFFF, 32'h7F);
        chk("R2 clk_div", 32'(clk_div), 32'h7F);
        rd_chk("R9 status link on", 8'h0C, 32'hFFFF_FFFF, 32'h09);
        chk("R10 irq from tx service", {31'b0, irq}, 32'h1);

        // R11 soft reset flushes data and registers
        wr(8'h80, 32'h1111_0000);
        wr(8'h80, 32'h2222_0000);
        @(negedge clk); rx_push = 1'b1; rx_word = 32'hABCD;
        @(negedge clk); rx_push = 1'b0;
        wr(8'h00, 32'h8);
        rd_chk("R11 ctrl", 8'h00, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R11 fmt", 8'h04, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R11 mask", 8'h14, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R11 div", 8'h60, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R11 status", 8'h0C, 32'hFFFF_FFFF, 32'h99);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R3 transmit ordering and full drop
        wr(8'h00, 32'h1);
        for (int i = 0; i < 17; i++) send_tx(32'hC0DE_0000 + 32'(i * 7));
        rd_chk("R3 full status", 8'h0C, 32'hFFFF_FFFF, 32'h10);
        for (int i = 0; i < 16; i++) take_tx("R3 tx order");
        rd_chk("R3 empty status", 8'h0C, 32'hFFFF_FFFF, 32'h19);

        // R6 underrun gating by playback disable
        wr(8'h04, 32'h10);
        pulse_pop();
        rd_chk("R6 no underrun when playback off", 8'h0C, 32'h20, 32'h0);
        wr(8'h04, 32'h0);
        pulse_pop();
        rd_chk("R6 underrun set", 8'h0C, 32'h20, 32'h20);

        // R7 write-one-to-clear
        wr(8'h18, 32'h40);
        rd_chk("R7 other bit ignored", 8'h0C, 32'h20, 32'h20);
        wr(8'h18, 32'h0);
        rd_chk("R7 zero ignored", 8'h0C, 32'h20, 32'h20);
        wr(8'h18, 32'h20);
        rd_chk("R7 underrun cleared", 8'h0C, 32'h20, 32'h0);

        // R4 / R5 receive path and overrun
        for (int i = 0; i < 17; i++) feed_rx(32'h5A00_0000 + 32'(i * 13));
        rd_chk("R5 overrun status", 8'h0C, 32'hFFFF_FFFF, 32'h5B);
        wr(8'h14, 32'h40);
        chk("R10 irq overrun unmasked", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h0);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 16; i++) drain_rx("R4 rx order");
        rd_chk("R4 empty read", 8'h80, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R4 not-empty bit", 8'h0C, 32'h02, 32'h0);
        wr(8'h18, 32'h40);
        rd_chk("R7 overrun cleared", 8'h0C, 32'h40, 32'h0);

        // R8 thresholds: tx 3, rx 2
        wr(8'h00, 32'h2301);
        for (int i = 0; i < 3; i++) send_tx(32'h7700 + 32'(i));
        rd_chk("R8 tx at threshold", 8'h0C, 32'h08, 32'h08);
        send_tx(32'h7703);
        rd_chk("R8 tx above threshold", 8'h0C, 32'h08, 32'h0);
        feed_rx(32'h0001_0001);
        rd_chk("R8 rx below threshold", 8'h0C, 32'h10, 32'h0);
        feed_rx(32'h0002_0002);
        rd_chk("R8 rx at threshold", 8'h0C, 32'h10, 32'h10);
        for (int i = 0; i < 4; i++) take_tx("R3 tx order after thresholds");
        for (int i = 0; i < 2; i++) drain_rx("R4 rx order after thresholds");

        // R9 busy and off
        frame_active = 1'b1;
        rd_chk("R9 busy", 8'h0C, 32'h84, 32'h04);
        wr(8'h00, 32'h0);
        rd_chk("R9 off", 8'h0C, 32'h84, 32'h80);
        frame_active = 1'b0;

        // R7 a new event wins over its clear in the same cycle
        for (int i = 0; i < 16; i++) feed_rx(32'h3300 + 32'(i));
        @(negedge clk);
        rx_push = 1'b1; rx_word = 32'hDEAD;
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h40;
        @(negedge clk);
        rx_push = 1'b0; bus_wr = 1'b0;
        rd_chk("R7 set beats clear", 8'h0C, 32'h40, 32'h40);
        for (int i = 0; i < 16; i++) drain_rx("R5 full fifo kept old words");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule